// File: doc/BRIEF.md
# Periodic Alarm Repeat Controller

This block holds four programmable alarm fields (seconds, minutes, hours and day of month) and compares them against the BCD time of day and date that an external timekeeping counter supplies. Each alarm byte has a mask flag in its top bit. The four mask flags together pick how often the alarm repeats: once a month, once a day, once an hour, once a minute or every second. On a match the block emits a single-cycle interrupt pulse.

Software programs the alarm through a byte-wide register port. A write to an alarm field is dropped unless the BCD value in its value bits is legal for that field, so a stored alarm never holds an impossible time. A one-bit enable gates the interrupt. The comparison runs only on the cycle that the external once-per-second strobe is high, so each second can give at most one pulse.

The register port and the time bus are plain control inputs with no valid/ready handshake. A write completes in the cycle it is presented and the port never applies back-pressure. Read data is a combinational function of the address. The time bus is sampled only when the second strobe is high.

Top module: `alarm_repeat_ctrl`

## Requirements
- R1: After reset every alarm field reads 0x00, the enable bit reads 0 and `irq_pulse` is low.
- R2: Register addresses are 0 = alarm seconds, 1 = alarm minutes, 2 = alarm hours, 3 = alarm date and 4 = control, where bit 0 is the interrupt enable and the other bits read 0. An accepted alarm write reads back as the exact byte written, including bit 7 (the mask flag). Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: A write to alarm seconds or alarm minutes is accepted only if bits 6:0, read as two BCD digits, have both digits at most 9 and a value of 00 to 59. Otherwise the field keeps its previous byte.
- R4: A write to alarm hours is accepted only if bits 5:0 form valid BCD from 00 to 23. Otherwise the field keeps its previous byte.
- R5: A write to alarm date is accepted only if bits 4:0 form valid BCD that is not zero (01 to 19). Otherwise the field keeps its previous byte.
- R6: With all four mask flags clear, a strobe fires when date (bits 4:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) of the time bus all equal the alarm fields.
- R7: With only the date mask set, a strobe fires when hours, minutes and seconds match.
- R8: With the date and hours masks set and the others clear, a strobe fires when minutes and seconds match.
- R9: With the date, hours and minutes masks set and the seconds mask clear, a strobe fires when seconds match.
- R10: Every other mask combination fires on every strobe.
- R11: A firing strobe sampled at a clock edge raises `irq_pulse` for exactly the following cycle. `irq_pulse` is never high except in the cycle after a strobe.
- R12: While the enable bit is 0, no strobe raises `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
The assertions assume that `sec_tick` lasts one cycle and is separated from the next strobe by idle cycles, and that the time bus is stable in the cycle the strobe is sampled. The pulse checks tie `irq_pulse` to the strobe and to the enable in the previous cycle only. The stimulus drives every input on the falling clock edge. It leaves at least two idle cycles after each strobe and makes at most one register write per cycle. Random bytes, with and without the mask flag, reach every field, including illegal digits and out-of-range values. Random times are often copied from the stored alarm with one field disturbed, so that near-miss matches occur in every repeat mode.

// File: rtl/alarm_rpt_pkg.sv
package alarm_rpt_pkg;

  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 4;

  // field order: 0 seconds, 1 minutes, 2 hours, 3 date
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } rpt_mode_e;

  typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_bus_t;

  // number of value bits below the mask flag for each field
  function automatic int fld_bits(int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 7;
      FLD_HOUR:         return 6;
      default:          return 5;
    endcase
  endfunction

  function automatic int fld_max(int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 59;
      FLD_HOUR:         return 23;
      default:          return 31;
    endcase
  endfunction

  function automatic int fld_min(int idx);
    return (idx == FLD_DATE) ? 1 : 0;
  endfunction

  function automatic logic [BYTE_W-1:0] fld_value_mask(int idx);
    return BYTE_W'((1 << fld_bits(idx)) - 1);
  endfunction

endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import alarm_rpt_pkg::*;
#(
  parameter int FIELD_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] q,
  output logic [BYTE_W-1:0] value,
  output logic              mask_flag
);

  localparam logic [BYTE_W-1:0] VAL_MASK = fld_value_mask(FIELD_IDX);
  localparam int                LO_LIMIT = fld_min(FIELD_IDX);
  localparam int                HI_LIMIT = fld_max(FIELD_IDX);

  logic [BYTE_W-1:0] cand;
  logic              lo_digit_ok;
  logic              hi_digit_ok;
  logic              range_ok;
  logic              accept;
  int                cand_dec;

  // screen the candidate value bits before they may be stored
  always_comb begin
    cand        = wdata & VAL_MASK;
    lo_digit_ok = (cand[3:0] <= 4'd9);
    hi_digit_ok = (cand[7:4] <= 4'd9);
    cand_dec    = int'(cand[7:4]) * 10 + int'(cand[3:0]);
    range_ok    = (cand_dec >= LO_LIMIT) && (cand_dec <= HI_LIMIT);
    accept      = lo_digit_ok && hi_digit_ok && range_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en && accept) begin
      q <= wdata;
    end
  end

  assign value     = q & VAL_MASK;
  assign mask_flag = q[BYTE_W-1];

  // R3 R4 R5: an illegal write leaves the stored byte untouched
  p_reject_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> $stable(q));

  // R2: a legal write stores the whole byte, mask flag included
  p_accept_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && accept) |=> (q == $past(wdata)));

endmodule

// File: rtl/alarm_repeat_decode.sv
module alarm_repeat_decode
  import alarm_rpt_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] mask_bits,
  output logic [NUM_FIELDS-1:0] need_eq
);

  rpt_mode_e mode;

  // mask pattern, bit index = field index (date is bit 3)
  always_comb begin
    case (mask_bits)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (mode)
      RPT_MONTH:  need_eq = 4'b1111;
      RPT_DAY:    need_eq = 4'b0111;
      RPT_HOUR:   need_eq = 4'b0011;
      RPT_MINUTE: need_eq = 4'b0001;
      default:    need_eq = 4'b0000;
    endcase
  end

  // R10: a masked seconds flag always means firing every second
  always_comb begin
    p_sec_mask_every_second_r10: assert (!mask_bits[FLD_SEC] || (need_eq == 4'b0000));
  end

endmodule

// File: rtl/alarm_match_pulse.sv
module alarm_match_pulse
  import alarm_rpt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sec_tick,
  input  logic                  enable,
  input  logic [NUM_FIELDS-1:0] need_eq,
  input  field_bus_t            alarm_val,
  input  field_bus_t            tod_val,
  output logic                  irq
);

  logic [NUM_FIELDS-1:0] field_eq;
  logic                  hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    localparam logic [BYTE_W-1:0] CMP_MASK = fld_value_mask(g);
    assign field_eq[g] = (((alarm_val[g] ^ tod_val[g]) & CMP_MASK) == '0);
  end

  assign hit = &(field_eq | ~need_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= sec_tick && enable && hit;
    end
  end

  // R11: the pulse only follows a sampled strobe
  p_pulse_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sec_tick));

  // R12: no pulse unless enabled when the strobe was sampled
  p_no_irq_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(enable));

endmodule

// File: rtl/alarm_repeat_ctrl.sv
module alarm_repeat_ctrl
  import alarm_rpt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              sec_tick,
  input  logic [BYTE_W-1:0] tod_sec,
  input  logic [BYTE_W-1:0] tod_min,
  input  logic [BYTE_W-1:0] tod_hour,
  input  logic [BYTE_W-1:0] tod_date,
  output logic              irq_pulse
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

  field_bus_t            fld_q;
  field_bus_t            fld_val;
  field_bus_t            tod_bus;
  logic [NUM_FIELDS-1:0] fld_mask;
  logic [NUM_FIELDS-1:0] need_eq;
  logic                  alarm_en;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    alarm_field_reg #(.FIELD_IDX(g)) u_field (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en && (reg_addr == ADDR_W'(g))),
      .wdata    (reg_wdata),
      .q        (fld_q[g]),
      .value    (fld_val[g]),
      .mask_flag(fld_mask[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_en <= 1'b0;
    end else if (reg_wr_en && (reg_addr == CTRL_ADDR)) begin
      alarm_en <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < CTRL_ADDR) begin
      reg_rdata = fld_q[reg_addr[1:0]];
    end else if (reg_addr == CTRL_ADDR) begin
      reg_rdata = {{(BYTE_W-1){1'b0}}, alarm_en};
    end
  end

  assign tod_bus[FLD_SEC]  = tod_sec;
  assign tod_bus[FLD_MIN]  = tod_min;
  assign tod_bus[FLD_HOUR] = tod_hour;
  assign tod_bus[FLD_DATE] = tod_date;

  alarm_repeat_decode u_decode (
    .mask_bits(fld_mask),
    .need_eq  (need_eq)
  );

  alarm_match_pulse u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .enable   (alarm_en),
    .need_eq  (need_eq),
    .alarm_val(fld_val),
    .tod_val  (tod_bus),
    .irq      (irq_pulse)
  );

  // R2: the enable bit only changes through a control write
  p_en_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && (reg_addr == CTRL_ADDR)) |=> $stable(alarm_en));

endmodule

// File: tb/alarm_repeat_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_repeat_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sec_tick = 1'b0;
  logic [7:0] tod_sec = '0, tod_min = '0, tod_hour = '0, tod_date = '0;
  logic       irq_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] m [0:4];

  always #2.5 clk = ~clk;

  alarm_repeat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
    .tod_date(tod_date), .irq_pulse(irq_pulse)
  );

  function automatic logic [7:0] vmask(int idx);
    case (idx)
      0, 1: return 8'h7F;
      2:    return 8'h3F;
      default: return 8'h1F;
    endcase
  endfunction

  function automatic bit b_accept(int idx, logic [7:0] d);
    logic [7:0] v;
    int dec;
    v = d & vmask(idx);
    if (v[3:0] > 4'd9 || v[7:4] > 4'd9) return 0;
    dec = v[7:4] * 10 + v[3:0];
    case (idx)
      0, 1: return dec <= 59;
      2:    return dec <= 23;
      default: return dec >= 1;
    endcase
  endfunction

  function automatic bit b_fire(logic [7:0] ts, logic [7:0] tm, logic [7:0] th, logic [7:0] td);
    bit es, em, eh, ed;
    logic [3:0] mk;
    if (!m[4][0]) return 0;
    es = ((ts ^ m[0]) & 8'h7F) == 0;
    em = ((tm ^ m[1]) & 8'h7F) == 0;
    eh = ((th ^ m[2]) & 8'h3F) == 0;
    ed = ((td ^ m[3]) & 8'h1F) == 0;
    mk = {m[3][7], m[2][7], m[1][7], m[0][7]};
    if (mk == 4'b0000) return es && em && eh && ed;
    if (mk == 4'b1000) return es && em && eh;
    if (mk == 4'b1100) return es && em;
    if (mk == 4'b1110) return es;
    return 1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a < 3'd4) begin
      if (b_accept(int'(a), d)) m[a] = d;
    end else if (a == 3'd4) begin
      m[4] = {7'b0, d[0]};
    end
  endtask

  task automatic read_chk(logic [2:0] a, string req);
    logic [7:0] e;
    reg_addr = a;
    #1;
    e = (a <= 3'd4) ? m[a] : 8'h00;
    chk(req, reg_rdata, e);
  endtask

  task automatic do_tick(logic [7:0] ts, logic [7:0] tm, logic [7:0] th, logic [7:0] td, string req);
    bit e;
    e = b_fire(ts, tm, th, td);
    @(negedge clk);
    tod_sec = ts; tod_min = tm; tod_hour = th; tod_date = td; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    chk(req, {7'b0, irq_pulse}, {7'b0, e});
    @(negedge clk);
    chk("R11 pulse ends", {7'b0, irq_pulse}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ts, tm, th, td;
    for (int i = 0; i < 5; i++) m[i] = 8'h00;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) read_chk(3'(a), "R1 reset value");
    chk("R1 irq low", {7'b0, irq_pulse}, 8'h00);

    // R3 seconds/minutes screening
    do_write(3'd0, 8'h59); read_chk(3'd0, "R3 accept 59");
    do_write(3'd0, 8'h60); read_chk(3'd0, "R3 reject 60");
    do_write(3'd0, 8'h5A); read_chk(3'd0, "R3 reject bad digit");
    do_write(3'd1, 8'hC7); read_chk(3'd1, "R3 mask flag with 47");
    // R4 hours screening
    do_write(3'd2, 8'h23); read_chk(3'd2, "R4 accept 23");
    do_write(3'd2, 8'h24); read_chk(3'd2, "R4 reject 24");
    do_write(3'd2, 8'hA1); read_chk(3'd2, "R4 accept upper bits kept");
    // R5 date screening
    do_write(3'd3, 8'h00); read_chk(3'd3, "R5 reject zero");
    do_write(3'd3, 8'h19); read_chk(3'd3, "R5 accept 19");
    do_write(3'd3, 8'h80); read_chk(3'd3, "R5 reject masked zero");
    do_write(3'd3, 8'h1A); read_chk(3'd3, "R5 reject bad digit");
    // R2 unmapped and control
    do_write(3'd6, 8'hFF); read_chk(3'd6, "R2 unmapped reads zero");
    for (int a = 0; a < 4; a++) read_chk(3'(a), "R2 unmapped write no effect");
    do_write(3'd4, 8'hFF); read_chk(3'd4, "R2 control enable");

    // set up a monthly alarm: date 12, 08:30:45
    do_write(3'd3, 8'h12); do_write(3'd2, 8'h08);
    do_write(3'd1, 8'h30); do_write(3'd0, 8'h45);
    do_tick(8'h45, 8'h30, 8'h08, 8'h12, "R6 monthly hit");
    do_tick(8'h45, 8'h30, 8'h08, 8'h13, "R6 monthly date miss");
    // R12 disabled
    do_write(3'd4, 8'h00);
    do_tick(8'h45, 8'h30, 8'h08, 8'h12, "R12 disabled no pulse");
    do_write(3'd4, 8'h01);
    // R7 daily
    do_write(3'd3, 8'h92);
    do_tick(8'h45, 8'h30, 8'h08, 8'h05, "R7 daily hit other date");
    do_tick(8'h45, 8'h30, 8'h09, 8'h12, "R7 daily hour miss");
    // R8 hourly
    do_write(3'd2, 8'h88);
    do_tick(8'h45, 8'h30, 8'h17, 8'h01, "R8 hourly hit");
    do_tick(8'h45, 8'h31, 8'h08, 8'h12, "R8 hourly minute miss");
    // R9 minute
    do_write(3'd1, 8'hB0);
    do_tick(8'h45, 8'h02, 8'h03, 8'h04, "R9 minute hit");
    do_tick(8'h46, 8'h30, 8'h08, 8'h12, "R9 minute second miss");
    // R10 every second
    do_write(3'd0, 8'hC5);
    do_tick(8'h01, 8'h02, 8'h03, 8'h04, "R10 every second");
    do_write(3'd2, 8'h08);
    do_tick(8'h11, 8'h22, 8'h13, 8'h14, "R10 irregular mask combo");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        logic [2:0] a;
        logic [7:0] d;
        a = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
        d = 8'($urandom);
        if ($urandom_range(0, 1) == 1) d = {d[7], 3'($urandom_range(0, 5)), 4'($urandom_range(0, 9))};
        if (a == 3'd4) d[0] = ($urandom_range(0, 5) != 0);
        do_write(a, d);
        read_chk(a, "R2 random readback");
      end else begin
        if ($urandom_range(0, 1) == 1) begin
          ts = m[0]; tm = m[1]; th = m[2]; td = m[3];
          case ($urandom_range(0, 5))
            0: ts = 8'($urandom);
            1: tm = 8'($urandom);
            2: th = 8'($urandom);
            3: td = 8'($urandom);
            default: ;
          endcase
        end else begin
          ts = 8'($urandom); tm = 8'($urandom); th = 8'($urandom); td = 8'($urandom);
        end
        do_tick(ts, tm, th, td, "R6 R7 R8 R9 R10 random tick");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule